// File: doc/BRIEF.md
# Descriptor-Driven Transmit DMA Channel

This block moves one outgoing frame at a time from shared memory to a byte-wide stream sink. Software places a four-word descriptor in memory and writes its address into the head pointer. The channel then reads the descriptor and checks that it is a complete frame handed to hardware. It reads the buffer the descriptor points at and offers each byte on a valid/ready stream, with the first and last bytes marked.

When the last byte has been taken, the channel writes the flags word of the descriptor back to memory. In that word it returns ownership to software and records whether the queue ended. It then latches the descriptor address as the completion pointer and raises a raw completion status bit. Software acknowledges the frame by writing that same address to the completion pointer. A non-zero next pointer makes the channel go on to the following descriptor. A teardown command abandons the work in progress and parks the completion pointer at a fixed marker.

Top module: `txdma_channel`

## Requirements
- R1: After reset the stream is idle, `busy` is low, the raw status is 0, the completion pointer reads 0, and no memory access is made.
- R2: A head write (`sw_sel` = 0) with a non-zero address while idle fetches four words at that address and the next three word addresses. Word 0 is the next pointer, word 1 the buffer byte address, word 2 bits 31:16 a byte offset, and word 3 the flags/length word. Memory read data returns one cycle after `mem_rd`.
- R3: The number of bytes sent equals word 3 bits 15:0. Bytes are read starting at byte address buffer + offset, with byte k of a memory word taken from bits 8k+7:8k.
- R4: A byte is transferred when `tx_valid` and `tx_ready` are both high. `tx_sop` marks the first byte and `tx_eof` the last. A byte that is offered but not taken stays unchanged on the stream.
- R5: After the last byte, word 3 is written back with bit 29 (owner) cleared and bit 28 (end of queue) set exactly when the next pointer is zero; all other bits are kept. The raw status then becomes 1 and the completion pointer holds the descriptor address.
- R6: A completion write (`sw_sel` = 1) whose data equals the completion pointer clears the raw status. Any other data leaves it set. When a write-back happens in the same cycle as such a write, the status stays set.
- R7: A descriptor that lacks any of bit 31 (start), bit 30 (end) or bit 29 (owner) in word 3 sends no byte and gets no write-back. The raw status is left as it was and the channel returns to idle.
- R8: A non-zero next pointer makes the channel fetch and send the descriptor at that address after the current write-back, with no software action.
- R9: A head write while `busy` is high has no effect.
- R10: A teardown command (`sw_sel` = 2) makes the completion pointer read 0xFFFFFFFC from the next cycle. It stops the stream at once and suppresses any pending write-back.
- R11: A descriptor with length 0 that is otherwise valid sends no byte but is still written back and completed as in R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Software write strobe |
| sw_sel | input | 2 | Write target: 0 head, 1 completion, 2 teardown, 3 none |
| sw_wdata | input | 32 | Software write data |
| busy | output | 1 | Channel is processing descriptors |
| raw_status | output | 1 | Raw completion status bit |
| comp_ptr | output | 32 | Completion pointer |
| mem_rd | output | 1 | Memory word read request |
| mem_we | output | 1 | Memory word write request |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after `mem_rd` |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_data | output | 8 | Stream byte |
| tx_sop | output | 1 | First byte of frame |
| tx_eof | output | 1 | Last byte of frame |

## Verification
The descriptor write-back that sets the raw status and a software acknowledge that clears it can land on the same clock edge. The bench provokes this with two chained descriptors. It watches the memory write strobe and issues the acknowledge for the first descriptor in exactly the cycle the second one is written back. The per-clock reference model gives the write-back priority, so it expects the status to stay high and the completion pointer to move to the second descriptor. A later acknowledge with that address must then clear the status.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

    localparam int FLG_SOP = 31;
    localparam int FLG_EOP = 30;
    localparam int FLG_OWN = 29;
    localparam int FLG_EOQ = 28;

    localparam logic [31:0] TDOWN_CODE = 32'hFFFF_FFFC;

    typedef enum logic [1:0] {
        SEL_HEAD  = 2'd0,
        SEL_COMP  = 2'd1,
        SEL_TDOWN = 2'd2,
        SEL_NONE  = 2'd3
    } sw_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_CHECK, ST_STREAM, ST_WB
    } ctrl_st_e;

    typedef enum logic [2:0] {
        SS_IDLE, SS_ISSUE, SS_WAIT, SS_SEND, SS_FIN
    } str_st_e;

    typedef struct packed {
        logic [31:0] next;
        logic [31:0] buf_addr;
        logic [15:0] offset;
        logic [31:0] flags_len;
    } txdesc_t;

    function automatic logic desc_ready(input logic [31:0] w);
        return w[FLG_SOP] & w[FLG_EOP] & w[FLG_OWN];
    endfunction

    function automatic logic [31:0] wb_word(input logic [31:0] w, input logic last);
        logic [31:0] r;
        r          = w;
        r[FLG_OWN] = 1'b0;
        r[FLG_EOQ] = last;
        return r;
    endfunction

    function automatic logic [7:0] byte_lane(input logic [31:0] w, input logic [1:0] k);
        return 8'(w >> {k, 3'b000});
    endfunction

endpackage

// File: rtl/txdma_regs.sv
module txdma_regs
    import txdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sw_we,
    input  logic [1:0]  sw_sel,
    input  logic [31:0] sw_wdata,
    input  logic        busy,
    input  logic        complete,
    input  logic [31:0] cur_addr,
    output logic        head_wr,
    output logic        tdown,
    output logic        raw,
    output logic [31:0] cp
);
    sw_sel_e sel;
    logic    ack;

    assign sel     = sw_sel_e'(sw_sel);
    assign head_wr = sw_we && (sel == SEL_HEAD) && !busy;
    assign tdown   = sw_we && (sel == SEL_TDOWN);
    assign ack     = sw_we && (sel == SEL_COMP) && (sw_wdata == cp);

    always_ff @(posedge clk) begin
        if (rst) begin
            raw <= 1'b0;
            cp  <= '0;
        end else begin
            if (tdown)
                cp <= TDOWN_CODE;
            else if (complete)
                cp <= cur_addr;
            // a fresh completion outranks an acknowledge in the same cycle
            if (complete)
                raw <= 1'b1;
            else if (ack)
                raw <= 1'b0;
        end
    end
endmodule

// File: rtl/txdma_streamer.sv
module txdma_streamer
    import txdma_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             abort,
    input  logic [31:0]      start_addr,
    input  logic [LEN_W-1:0] length,
    input  logic [31:0]      rdata,
    input  logic             tx_ready,
    output logic             rd_req,
    output logic [31:0]      rd_addr,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_sop,
    output logic             tx_eof,
    output logic             done
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

    str_st_e          st;
    logic [31:0]      ptr;
    logic [LEN_W-1:0] remain;
    logic [31:0]      word;
    logic             first;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SS_IDLE;
            ptr    <= '0;
            remain <= '0;
            word   <= '0;
            first  <= 1'b0;
        end else if (abort) begin
            st <= SS_IDLE;
        end else begin
            case (st)
                SS_IDLE: if (start) begin
                    ptr    <= start_addr;
                    remain <= length;
                    first  <= 1'b1;
                    st     <= (length == '0) ? SS_FIN : SS_ISSUE;
                end
                SS_ISSUE: st <= SS_WAIT;
                SS_WAIT: begin
                    word <= rdata;
                    st   <= SS_SEND;
                end
                SS_SEND: if (tx_ready) begin
                    ptr    <= ptr + 32'd1;
                    remain <= remain - ONE;
                    first  <= 1'b0;
                    if (remain == ONE)
                        st <= SS_FIN;
                    else if (ptr[1:0] == 2'b11)
                        st <= SS_ISSUE;
                end
                SS_FIN:  st <= SS_IDLE;
                default: st <= SS_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_req   = (st == SS_ISSUE);
        rd_addr  = {ptr[31:2], 2'b00};
        tx_valid = (st == SS_SEND);
        tx_data  = byte_lane(word, ptr[1:0]);
        tx_sop   = tx_valid && first;
        tx_eof   = tx_valid && (remain == ONE);
        done     = (st == SS_FIN);
    end
endmodule

// File: rtl/txdma_ctrl.sv
module txdma_ctrl
    import txdma_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             head_wr,
    input  logic [31:0]      head_addr,
    input  logic             tdown,
    input  logic [31:0]      rdata,
    input  logic             stream_done,
    output logic             rd_req,
    output logic [31:0]      rd_addr,
    output logic             wr_req,
    output logic [31:0]      wr_addr,
    output logic [31:0]      wr_data,
    output logic             stream_start,
    output logic [31:0]      stream_addr,
    output logic [LEN_W-1:0] stream_len,
    output logic             complete,
    output logic [31:0]      cur_addr,
    output logic             busy
);
    localparam int WORDS = 4;
    localparam int CNT_W = $clog2(WORDS + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WORDS);

    ctrl_st_e         st;
    logic [31:0]      dsc_addr;
    logic [CNT_W-1:0] cnt;
    txdesc_t          dsc;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            dsc_addr <= '0;
            cnt      <= '0;
            dsc      <= '0;
        end else if (tdown) begin
            st <= ST_IDLE;
        end else begin
            case (st)
                ST_IDLE: if (head_wr && head_addr != '0) begin
                    dsc_addr <= head_addr;
                    cnt      <= '0;
                    st       <= ST_FETCH;
                end
                ST_FETCH: begin
                    cnt <= cnt + 1'b1;
                    case (cnt)
                        CNT_W'(1): dsc.next      <= rdata;
                        CNT_W'(2): dsc.buf_addr  <= rdata;
                        CNT_W'(3): dsc.offset    <= rdata[31:16];
                        CNT_W'(4): dsc.flags_len <= rdata;
                        default: ;
                    endcase
                    if (cnt == LAST_CNT)
                        st <= ST_CHECK;
                end
                ST_CHECK:  st <= desc_ready(dsc.flags_len) ? ST_STREAM : ST_IDLE;
                ST_STREAM: if (stream_done) st <= ST_WB;
                ST_WB: begin
                    if (dsc.next != '0) begin
                        dsc_addr <= dsc.next;
                        cnt      <= '0;
                        st       <= ST_FETCH;
                    end else begin
                        st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_req       = (st == ST_FETCH) && (cnt < LAST_CNT);
        rd_addr      = dsc_addr + (32'(cnt) << 2);
        wr_req       = (st == ST_WB) && !tdown;
        wr_addr      = dsc_addr + 32'd12;
        wr_data      = wb_word(dsc.flags_len, dsc.next == '0);
        stream_start = (st == ST_CHECK) && desc_ready(dsc.flags_len);
        stream_addr  = dsc.buf_addr + {16'h0000, dsc.offset};
        stream_len   = dsc.flags_len[LEN_W-1:0];
        complete     = wr_req;
        cur_addr     = dsc_addr;
        busy         = (st != ST_IDLE);
    end
endmodule

// File: rtl/txdma_channel.sv
module txdma_channel
    import txdma_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sw_we,
    input  logic [1:0]  sw_sel,
    input  logic [31:0] sw_wdata,
    output logic        busy,
    output logic        raw_status,
    output logic [31:0] comp_ptr,
    output logic        mem_rd,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [7:0]  tx_data,
    output logic        tx_sop,
    output logic        tx_eof
);
    logic             head_wr, tdown, complete, s_start, s_done;
    logic             c_rd, c_wr, s_rd;
    logic [31:0]      c_raddr, c_waddr, c_wdata, s_raddr, s_addr, cur_addr;
    logic [LEN_W-1:0] s_len;

    txdma_regs u_regs (
        .clk(clk), .rst(rst), .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
        .busy(busy), .complete(complete), .cur_addr(cur_addr),
        .head_wr(head_wr), .tdown(tdown), .raw(raw_status), .cp(comp_ptr)
    );

    txdma_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst(rst), .head_wr(head_wr), .head_addr(sw_wdata), .tdown(tdown),
        .rdata(mem_rdata), .stream_done(s_done),
        .rd_req(c_rd), .rd_addr(c_raddr), .wr_req(c_wr), .wr_addr(c_waddr), .wr_data(c_wdata),
        .stream_start(s_start), .stream_addr(s_addr), .stream_len(s_len),
        .complete(complete), .cur_addr(cur_addr), .busy(busy)
    );

    txdma_streamer #(.LEN_W(LEN_W)) u_str (
        .clk(clk), .rst(rst), .start(s_start), .abort(tdown), .start_addr(s_addr),
        .length(s_len), .rdata(mem_rdata), .tx_ready(tx_ready),
        .rd_req(s_rd), .rd_addr(s_raddr), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_sop(tx_sop), .tx_eof(tx_eof), .done(s_done)
    );

    always_comb begin
        mem_rd    = c_rd | s_rd;
        mem_we    = c_wr;
        mem_wdata = c_wdata;
        if (c_wr)
            mem_addr = c_waddr;
        else if (c_rd)
            mem_addr = c_raddr;
        else
            mem_addr = s_raddr;
    end
endmodule

// File: rtl/txdma_channel_chk.sv
module txdma_channel_chk
    import txdma_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        sw_we,
    input logic [1:0]  sw_sel,
    input logic [31:0] sw_wdata,
    input logic        busy,
    input logic        raw_status,
    input logic [31:0] comp_ptr,
    input logic        mem_rd,
    input logic        mem_we,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic [7:0]  tx_data,
    input logic        tx_eof
);
    logic td_cmd, ack_cmd;
    assign td_cmd  = sw_we && (sw_sel == SEL_TDOWN);
    assign ack_cmd = sw_we && (sw_sel == SEL_COMP) && (sw_wdata == comp_ptr);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !tx_valid && !raw_status && comp_ptr == 32'h0 && !busy);

    assert_port_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_we));

    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready && !td_cmd |=> tx_valid && $stable(tx_data) && $stable(tx_eof));

    assert_eof_ends_R5: assert property (@(posedge clk) disable iff (rst)
        tx_valid && tx_ready && tx_eof |=> !tx_valid);

    assert_raw_source_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(raw_status) |-> $past(mem_we));

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
        ack_cmd && !mem_we |=> !raw_status);

    assert_tdown_cp_R10: assert property (@(posedge clk) disable iff (rst)
        td_cmd |=> comp_ptr == TDOWN_CODE && !tx_valid && !mem_we);
endmodule

bind txdma_channel txdma_channel_chk u_chk (
    .clk(clk), .rst(rst), .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
    .busy(busy), .raw_status(raw_status), .comp_ptr(comp_ptr), .mem_rd(mem_rd),
    .mem_we(mem_we), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_eof(tx_eof)
);

// File: tb/sim_txdma_channel.sv
`timescale 1ns/100ps
module sim_txdma_channel;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sw_we = 1'b0;
    logic [1:0]  sw_sel = 2'd3;
    logic [31:0] sw_wdata = '0;
    logic        busy, raw_status, mem_rd, mem_we, tx_valid, tx_sop, tx_eof;
    logic [31:0] comp_ptr, mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        tx_ready = 1'b1;
    logic [7:0]  tx_data;

    always #2.5 clk = ~clk;

    txdma_channel u0 (
        .clk(clk), .rst(rst), .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
        .busy(busy), .raw_status(raw_status), .comp_ptr(comp_ptr),
        .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_sop(tx_sop), .tx_eof(tx_eof)
    );

    // word memory, 1 KiB, one cycle read latency
    logic [31:0] mem [256];
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];
        if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    end

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // ready generation
    int       rdy_mode = 0;
    bit       rdy_fix  = 1'b1;
    bit [7:0] lfsr     = 8'hA5;
    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        tx_ready = (rdy_mode == 0) ? rdy_fix : lfsr[0];
    end

    // reference model state
    int          byte_q[$];
    logic [31:0] wb_addr_q[$];
    logic [31:0] wb_data_q[$];
    bit          exp_raw = 1'b0;
    logic [31:0] exp_cp  = '0;

    function automatic logic [7:0] get_byte(input logic [31:0] a);
        return 8'(mem[a[9:2]] >> (8 * a[1:0]));
    endfunction

    task automatic put_desc(input logic [31:0] a, input logic [31:0] nxt, input logic [31:0] bufa,
                            input logic [15:0] off, input logic [31:0] flags_len);
        mem[a[9:2]]       = nxt;
        mem[a[9:2] + 8'd1] = bufa;
        mem[a[9:2] + 8'd2] = {off, 16'h05EE};
        mem[a[9:2] + 8'd3] = flags_len;
    endtask

    // expected effect of one descriptor, from the requirements
    task automatic expect_desc(input logic [31:0] a);
        logic [31:0] nxt, bufa, w3, r;
        logic [15:0] off;
        int len;
        nxt  = mem[a[9:2]];
        bufa = mem[a[9:2] + 8'd1];
        off  = mem[a[9:2] + 8'd2][31:16];
        w3   = mem[a[9:2] + 8'd3];
        len  = int'(w3[15:0]);
        if (!(w3[31] && w3[30] && w3[29])) return;
        for (int i = 0; i < len; i++)
            byte_q.push_back({22'd0, (i == 0), (i == len - 1), get_byte(bufa + off + i)});
        r = w3; r[29] = 1'b0; r[28] = (nxt == 0);
        wb_addr_q.push_back(a + 12);
        wb_data_q.push_back(r);
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        #1;
        if (!rst && !done) begin
            bit          n_raw;
            logic [31:0] n_cp;
            chk(raw_status == exp_raw, "R6", "raw status", {31'd0, raw_status}, {31'd0, exp_raw});
            chk(comp_ptr == exp_cp, "R5", "completion pointer", comp_ptr, exp_cp);
            n_raw = exp_raw;
            n_cp  = exp_cp;
            if (tx_valid && tx_ready) begin
                if (byte_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected byte", {24'd0, tx_data}, 32'h0);
                end else begin
                    int e;
                    e = byte_q.pop_front();
                    chk({tx_sop, tx_eof, tx_data} == e[9:0], "R4", "byte/sop/eof",
                        {22'd0, tx_sop, tx_eof, tx_data}, e);
                end
            end
            if (sw_we && sw_sel == 2'd1 && sw_wdata == exp_cp) n_raw = 1'b0;
            if (mem_we) begin
                if (wb_addr_q.size() == 0) begin
                    chk(1'b0, "R7", "unexpected write-back", mem_addr, 32'h0);
                end else begin
                    logic [31:0] ea, ed;
                    ea = wb_addr_q.pop_front();
                    ed = wb_data_q.pop_front();
                    chk(mem_addr == ea, "R5", "write-back address", mem_addr, ea);
                    chk(mem_wdata == ed, "R5", "write-back word", mem_wdata, ed);
                    n_raw = 1'b1;
                    n_cp  = ea - 12;
                end
            end
            if (sw_we && sw_sel == 2'd2) begin
                byte_q.delete();
                wb_addr_q.delete();
                wb_data_q.delete();
                n_cp = 32'hFFFF_FFFC;
            end
            exp_raw = n_raw;
            exp_cp  = n_cp;
        end
    end

    task automatic sw_write(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        sw_we = 1'b1; sw_sel = sel; sw_wdata = d;
        @(negedge clk);
        sw_we = 1'b0; sw_sel = 2'd3;
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R1", "watchdog expired", 32'h0, 32'h1);
        finish_run();
    end

    localparam logic [31:0] GO = 32'hE000_0000;

    initial begin
        for (int w = 0; w < 256; w++)
            mem[w] = {8'(w * 28 + 24), 8'(w * 28 + 17), 8'(w * 28 + 10), 8'(w * 28 + 3)};
        put_desc(32'h100, 32'h0,   32'h200, 16'd0, GO | 32'd10);
        put_desc(32'h140, 32'h0,   32'h203, 16'd2, GO | 32'd9);
        put_desc(32'h180, 32'h0,   32'h210, 16'd0, 32'hC000_0000 | 32'd6);
        put_desc(32'h1C0, 32'h1E0, 32'h220, 16'd1, GO | 32'd5);
        put_desc(32'h1E0, 32'h0,   32'h230, 16'd0, GO | 32'd3);
        put_desc(32'h120, 32'h0,   32'h240, 16'd0, GO | 32'd40);
        put_desc(32'h160, 32'h0,   32'h210, 16'd0, GO | 32'd4);
        put_desc(32'h1A0, 32'h0,   32'h280, 16'd0, GO | 32'd30);
        put_desc(32'h0F0, 32'h0,   32'h2C0, 16'd0, GO);

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        // R1 reset state
        chk(!tx_valid && !busy && !mem_rd && !mem_we, "R1", "idle after reset",
            {28'd0, tx_valid, busy, mem_rd, mem_we}, 32'h0);
        chk(raw_status == 1'b0 && comp_ptr == 32'h0, "R1", "status after reset",
            comp_ptr, 32'h0);

        // R2 R3 R4 R5: plain frame, sink always ready
        expect_desc(32'h100);
        sw_write(2'd0, 32'h100);
        wait_idle();
        chk(raw_status == 1'b1, "R5", "raw set after frame", {31'd0, raw_status}, 32'h1);
        chk(mem[32'h10C >> 2] == ((GO & ~32'h2000_0000) | 32'h1000_0000 | 32'd10), "R5",
            "descriptor memory after write-back", mem[32'h10C >> 2], 32'hD000_000A);
        chk(byte_q.size() == 0, "R3", "all bytes sent", byte_q.size(), 0);

        // R6 wrong and matching acknowledge
        sw_write(2'd1, 32'h104);
        @(negedge clk); #1;
        chk(raw_status == 1'b1, "R6", "mismatched ack keeps raw", {31'd0, raw_status}, 32'h1);
        sw_write(2'd1, 32'h100);
        @(negedge clk); #1;
        chk(raw_status == 1'b0, "R6", "matching ack clears raw", {31'd0, raw_status}, 32'h0);

        // R3 R4 offset, unaligned start, back-pressure
        rdy_mode = 1;
        expect_desc(32'h140);
        sw_write(2'd0, 32'h140);
        wait_idle();
        chk(byte_q.size() == 0, "R3", "offset frame complete", byte_q.size(), 0);
        sw_write(2'd1, 32'h140);

        // R7 descriptor without owner
        sw_write(2'd0, 32'h180);
        wait_idle();
        chk(mem[32'h18C >> 2] == (32'hC000_0000 | 32'd6), "R7", "descriptor untouched",
            mem[32'h18C >> 2], 32'hC000_0006);
        chk(raw_status == 1'b0 && !busy, "R7", "no completion, idle", {31'd0, raw_status}, 32'h0);

        // R8 chain, with an acknowledge colliding with the second write-back (R6)
        rdy_mode = 0; rdy_fix = 1'b1;
        expect_desc(32'h1C0);
        expect_desc(32'h1E0);
        sw_write(2'd0, 32'h1C0);
        begin
            int seen = 0;
            while (seen < 2) begin
                @(negedge clk);
                if (mem_we) seen++;
            end
            sw_we = 1'b1; sw_sel = 2'd1; sw_wdata = 32'h1C0;
            @(negedge clk);
            sw_we = 1'b0; sw_sel = 2'd3;
            #1;
            chk(raw_status == 1'b1, "R6", "set wins over same-cycle ack", {31'd0, raw_status}, 32'h1);
            chk(comp_ptr == 32'h1E0, "R8", "pointer at chained descriptor", comp_ptr, 32'h1E0);
        end
        wait_idle();
        sw_write(2'd1, 32'h1E0);
        @(negedge clk); #1;
        chk(raw_status == 1'b0, "R6", "ack of chained descriptor", {31'd0, raw_status}, 32'h0);

        // R9 head write while busy is ignored
        rdy_fix = 1'b0;
        expect_desc(32'h120);
        sw_write(2'd0, 32'h120);
        repeat (12) @(negedge clk);
        sw_write(2'd0, 32'h160);
        rdy_fix = 1'b1;
        wait_idle();
        chk(mem[32'h16C >> 2] == (GO | 32'd4), "R9", "ignored descriptor untouched",
            mem[32'h16C >> 2], GO | 32'd4);
        sw_write(2'd1, 32'h120);

        // R10 teardown mid-frame
        rdy_mode = 1;
        expect_desc(32'h1A0);
        sw_write(2'd0, 32'h1A0);
        while (byte_q.size() > 22) @(negedge clk);
        sw_write(2'd2, 32'h0);
        #1;
        chk(comp_ptr == 32'hFFFF_FFFC, "R10", "teardown marker", comp_ptr, 32'hFFFF_FFFC);
        wait_idle();
        chk(!busy && !tx_valid, "R10", "channel stopped", {30'd0, busy, tx_valid}, 32'h0);
        chk(mem[32'h1AC >> 2] == (GO | 32'd30), "R10", "no write-back after teardown",
            mem[32'h1AC >> 2], GO | 32'd30);

        // R11 zero-length descriptor
        rdy_mode = 0;
        expect_desc(32'h0F0);
        sw_write(2'd0, 32'h0F0);
        wait_idle();
        chk(raw_status == 1'b1 && comp_ptr == 32'h0F0, "R11", "zero-length completes",
            comp_ptr, 32'h0F0);
        chk(wb_addr_q.size() == 0, "R11", "zero-length write-back seen", wb_addr_q.size(), 0);

        finish_run();
    end
endmodule